// File: doc/BRIEF.md
# Embedded sync video stream formatter

This block turns a 4:2:2 pixel byte stream into a line-locked 8-bit video stream in which line timing is carried inside the data itself. Every line is a fixed number of clock cycles. A free-running position counter places a start-of-active-video code (SAV) ahead of the active region and an end-of-active-video code (EAV) after it. The horizontal blanking between them is filled with the alternating blanking pattern. Each code is four bytes long. Its last byte carries the field flag, the vertical blanking flag and the horizontal flag, together with protection bits.

Pixels enter on a valid/ready interface. `in_ready` is high only during the active region, and a byte is taken in any cycle where `in_valid` and `in_ready` are both high. The output cannot stall. It emits one byte every clock, so a producer that has no byte ready at an active position does not pause the line. That position is filled with a substitute value, and which value depends on the format. Outside the active region the input is ignored.

Three formats are supported. Two of them use a fixed active window: 4:2:2 pixel data and sliced data. The third is raw mode, whose window is set by two 8-bit position values.

Top module: `vid_sync_formatter`

## Requirements
- R1: While reset is held, `out_byte` is 10H and `in_ready` is 0. The first line after reset uses the 4:2:2 format with the fixed window, and its SAV carries F=0 and V=1.
- R2: A line is LINE_LEN cycles long. In the fixed-window formats, positions 0..3 carry SAV, positions 4..ACT_LEN+3 are active, and the next four positions carry EAV. All remaining positions are blanking. `out_byte` shows the byte for position p one clock after the counter is at p.
- R3: Each timing code is the byte sequence FFH, 00H, 00H, status. In the status byte, bit 7 is 1, bit 6 is F, bit 5 is V, and bit 4 is H (0 in SAV, 1 in EAV). Bits 3..0 are V^H, F^H, F^V and F^V^H.
- R4: Blanking positions carry 80H and 10H alternately. The first blanking byte after an EAV is 80H. The alternation carries on across the end of the line up to the next SAV.
- R5: `field_in` and `vblank_in` are sampled only in the first cycle of an EAV. The sampled values appear in that EAV's status byte and in the status byte of the following SAV. Changes at any other time have no effect on the output.
- R6: `in_ready` is 1 exactly at the active positions. An accepted byte is output unchanged, except that 00H becomes 01H and FFH becomes FEH. `in_valid` and `in_data` have no effect outside the active region.
- R7: In the 4:2:2 format (`fmt_sel`=00), an active position with no valid byte outputs 80H at an even active index and 10H at an odd active index. The active index is the position minus 4.
- R8: In the sliced format (`fmt_sel`=01), an active position with no valid byte outputs 00H.
- R9: In raw mode (`fmt_sel`=10 or 11), SAV starts at raw_start×RAW_STEP and EAV starts at raw_stop×RAW_STEP. The active positions lie between them, and an active position with no valid byte outputs 00H. The settings must satisfy raw_start×RAW_STEP+4 < raw_stop×RAW_STEP and raw_stop×RAW_STEP+4 ≤ LINE_LEN.
- R10: `fmt_sel`, `raw_start` and `raw_stop` are sampled in the last cycle of a line and apply to the whole of the next line. Changes at any other time in the line have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Format select: 00 4:2:2, 01 sliced, 1x raw |
| raw_start | input | 8 | Raw-mode SAV position in units of RAW_STEP |
| raw_stop | input | 8 | Raw-mode EAV position in units of RAW_STEP |
| field_in | input | 1 | Field indication (0 first, 1 second) |
| vblank_in | input | 1 | Vertical blanking indication |
| in_valid | input | 1 | Pixel byte valid |
| in_data | input | 8 | Pixel byte |
| in_ready | output | 1 | High at active positions; byte taken when valid and ready are both high |
| out_byte | output | 8 | Formatted output stream, one byte per clock |

## Verification
The bench builds the block with LINE_LEN=64, ACT_LEN=40 and RAW_STEP=4. With these values a full line is only 64 cycles, so fourteen lines can cover every format, several raw windows and line-to-line format changes. The raw windows include one that ends at the last position of the line and one whose active region is only four bytes long, so both ends of the raw-window constraint are exercised. The step of 4 keeps every raw setting used by the bench within range of the 8-bit position values.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;
  typedef enum logic [1:0] {REG_BLANK, REG_SAV, REG_ACTIVE, REG_EAV} region_e;

  localparam logic [7:0] BLANK_EVEN = 8'h80;
  localparam logic [7:0] BLANK_ODD  = 8'h10;

  // status byte of a timing code: marker, flags, then protection bits
  function automatic logic [7:0] trs_status(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
endpackage

// File: rtl/vfmt_line_timer.sv
module vfmt_line_timer
  import vfmt_pkg::*;
#(
  parameter int LINE_LEN = 1716,
  parameter int ACT_LEN  = 1440,
  parameter int RAW_STEP = 8,
  localparam int HW = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    fmt_sel,
  input  logic [7:0]    raw_start,
  input  logic [7:0]    raw_stop,
  output logic [HW-1:0] hpos,
  output region_e       region,
  output logic [1:0]    trs_idx,
  output logic          eav_first,
  output logic [1:0]    cur_fmt
);
  logic [7:0]  lat_rs, lat_re;
  logic [31:0] sav_pos, eav_pos, h32;
  logic        line_end;

  assign line_end = (hpos == HW'(LINE_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hpos    <= '0;
      cur_fmt <= 2'b00;
      lat_rs  <= '0;
      lat_re  <= '0;
    end else if (line_end) begin
      hpos    <= '0;
      cur_fmt <= fmt_sel;
      lat_rs  <= raw_start;
      lat_re  <= raw_stop;
    end else begin
      hpos <= hpos + 1'b1;
    end
  end

  always_comb begin
    h32 = 32'(hpos);
    if (cur_fmt[1]) begin
      sav_pos = 32'(lat_rs) * 32'(RAW_STEP);
      eav_pos = 32'(lat_re) * 32'(RAW_STEP);
    end else begin
      sav_pos = 32'd0;
      eav_pos = 32'(ACT_LEN) + 32'd4;
    end
    trs_idx = 2'd0;
    if (h32 >= sav_pos && h32 < sav_pos + 32'd4) begin
      region  = REG_SAV;
      trs_idx = 2'(h32 - sav_pos);
    end else if (h32 >= sav_pos + 32'd4 && h32 < eav_pos) begin
      region = REG_ACTIVE;
    end else if (h32 >= eav_pos && h32 < eav_pos + 32'd4) begin
      region  = REG_EAV;
      trs_idx = 2'(h32 - eav_pos);
    end else begin
      region = REG_BLANK;
    end
  end

  assign eav_first = (region == REG_EAV) && (trs_idx == 2'd0);
endmodule

// File: rtl/vfmt_flags.sv
module vfmt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic eav_first,
  input  logic field_in,
  input  logic vblank_in,
  output logic f_q,
  output logic v_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_q <= 1'b0;
      v_q <= 1'b1;
    end else if (eav_first) begin
      f_q <= field_in;
      v_q <= vblank_in;
    end
  end
endmodule

// File: rtl/vfmt_byte_mux.sv
module vfmt_byte_mux
  import vfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  region_e    region,
  input  logic [1:0] trs_idx,
  input  logic [1:0] cur_fmt,
  input  logic       odd_pos,
  input  logic       f_q,
  input  logic       v_q,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic [7:0] out_byte
);
  logic       blank_tog;
  logic [7:0] nxt;

  always_comb begin
    unique case (region)
      REG_SAV, REG_EAV: begin
        case (trs_idx)
          2'd0:    nxt = 8'hFF;
          2'd3:    nxt = trs_status(f_q, v_q, region == REG_EAV);
          default: nxt = 8'h00;
        endcase
      end
      REG_ACTIVE: begin
        if (in_valid) begin
          if (in_data == 8'h00)      nxt = 8'h01;
          else if (in_data == 8'hFF) nxt = 8'hFE;
          else                       nxt = in_data;
        end else if (cur_fmt == 2'b00) begin
          nxt = odd_pos ? BLANK_ODD : BLANK_EVEN;
        end else begin
          nxt = 8'h00;
        end
      end
      default: nxt = blank_tog ? BLANK_ODD : BLANK_EVEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_byte  <= BLANK_ODD;
      blank_tog <= 1'b0;
    end else begin
      out_byte <= nxt;
      if (region == REG_EAV)        blank_tog <= 1'b0;
      else if (region == REG_BLANK) blank_tog <= ~blank_tog;
    end
  end
endmodule

// File: rtl/vid_sync_formatter.sv
module vid_sync_formatter
  import vfmt_pkg::*;
#(
  parameter int LINE_LEN = 1716,
  parameter int ACT_LEN  = 1440,
  parameter int RAW_STEP = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fmt_sel,
  input  logic [7:0] raw_start,
  input  logic [7:0] raw_stop,
  input  logic       field_in,
  input  logic       vblank_in,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic [7:0] out_byte
);
  localparam int HW = $clog2(LINE_LEN);

  logic [HW-1:0] hpos;
  region_e       region;
  logic [1:0]    trs_idx, cur_fmt;
  logic          eav_first, f_lat, v_lat;

  vfmt_line_timer #(.LINE_LEN(LINE_LEN), .ACT_LEN(ACT_LEN), .RAW_STEP(RAW_STEP)) u_timer (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .raw_start(raw_start), .raw_stop(raw_stop),
    .hpos(hpos), .region(region), .trs_idx(trs_idx), .eav_first(eav_first), .cur_fmt(cur_fmt)
  );

  vfmt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .eav_first(eav_first), .field_in(field_in),
    .vblank_in(vblank_in), .f_q(f_lat), .v_q(v_lat)
  );

  vfmt_byte_mux u_mux (
    .clk(clk), .rst_n(rst_n), .region(region), .trs_idx(trs_idx), .cur_fmt(cur_fmt),
    .odd_pos(hpos[0]), .f_q(f_lat), .v_q(v_lat), .in_valid(in_valid), .in_data(in_data),
    .out_byte(out_byte)
  );

  assign in_ready = (region == REG_ACTIVE);
endmodule

// File: rtl/vfmt_checker.sv
module vfmt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] out_byte,
  input logic       field_in,
  input logic       vblank_in,
  input logic       eav_first,
  input logic       f_q,
  input logic       v_q
);
  // R3: status byte after FF 00 00 carries marker and matching protection bits
  assert_status_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_byte, 3) == 8'hFF && $past(out_byte, 2) == 8'h00 && $past(out_byte, 1) == 8'h00)
    |-> (out_byte[7] && out_byte[3:0] == {out_byte[5] ^ out_byte[4], out_byte[6] ^ out_byte[4],
                                          out_byte[6] ^ out_byte[5], out_byte[6] ^ out_byte[5] ^ out_byte[4]}));

  // R6: an accepted byte never becomes a code marker value
  assert_clip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_byte != 8'h00 && out_byte != 8'hFF));

  // R5: flags hold outside the first EAV cycle
  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !eav_first |=> ($stable(f_q) && $stable(v_q)));

  // R5: flags take the inputs at the first EAV cycle
  assert_flags_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eav_first |=> (f_q == $past(field_in) && v_q == $past(vblank_in)));

  // R2: end of the active region is followed by the EAV marker
  assert_eav_after_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |=> out_byte == 8'hFF);

  // R2: active region opens right after an SAV status byte
  assert_sav_before_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (out_byte[7] && !out_byte[4]));
endmodule

bind vid_sync_formatter vfmt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .out_byte(out_byte),
  .field_in(field_in), .vblank_in(vblank_in), .eav_first(eav_first), .f_q(f_lat), .v_q(v_lat)
);

// File: tb/vid_sync_formatter_bench.sv
module vid_sync_formatter_bench;
  localparam int LINE_LEN = 64;
  localparam int ACT_LEN  = 40;
  localparam int RAW_STEP = 4;
  localparam int NLINES   = 14;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] fmt_sel;
  logic [7:0] raw_start, raw_stop, in_data, out_byte;
  logic       field_in, vblank_in, in_valid, in_ready;

  always #4 clk = ~clk;

  vid_sync_formatter #(.LINE_LEN(LINE_LEN), .ACT_LEN(ACT_LEN), .RAW_STEP(RAW_STEP)) u_vid_sync_formatter (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .raw_start(raw_start), .raw_stop(raw_stop),
    .field_in(field_in), .vblank_in(vblank_in), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_byte(out_byte)
  );

  logic [7:0] exp_q[$];
  string      tag_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  logic [1:0] cm[NLINES];
  logic [7:0] crs[NLINES], cre[NLINES];
  bit         gap[NLINES];

  // model state
  int hc, line, sp, ep;
  logic [1:0] mm;
  logic [7:0] mrs, mre;
  logic mf, mv, tog;
  logic [15:0] lfsr;

  function automatic logic [7:0] st(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h (line %0d)", tag, act, exp, line);
    end
  endtask

  task automatic set_line(input int k, input logic [1:0] m, input logic [7:0] s, input logic [7:0] e, input bit g);
    cm[k] = m; crs[k] = s; cre[k] = e; gap[k] = g;
  endtask

  // driver: drives inputs and pushes the expected byte for this cycle
  task automatic drive_cycle();
    logic [7:0] e;
    string t;
    int nk, idx;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    nk = (line + 1 < NLINES) ? line + 1 : 0;
    if (hc < LINE_LEN / 2) begin  // R10: junk config early in the line
      fmt_sel = lfsr[5:4]; raw_start = lfsr[15:8]; raw_stop = lfsr[7:0];
    end else begin
      fmt_sel = cm[nk]; raw_start = crs[nk]; raw_stop = cre[nk];
    end
    field_in  = lfsr[6];
    vblank_in = lfsr[9];
    in_valid  = gap[line] ? lfsr[2] : 1'b1;
    in_data   = (lfsr[3:1] == 3'd0) ? 8'h00 : (lfsr[3:1] == 3'd1) ? 8'hFF : lfsr[15:8];
    #1;
    sp = mm[1] ? int'(mrs) * RAW_STEP : 0;
    ep = mm[1] ? int'(mre) * RAW_STEP : ACT_LEN + 4;
    if (hc >= sp && hc < sp + 4) begin
      idx = hc - sp;
      e = (idx == 0) ? 8'hFF : (idx < 3) ? 8'h00 : st(mf, mv, 1'b0);
      t = (line == 0) ? "R1 R3 SAV" : (mm[1] ? "R3 R9 R10 SAV" : "R2 R3 R5 SAV");
    end else if (hc >= sp + 4 && hc < ep) begin
      if (in_valid) begin
        e = (in_data == 8'h00) ? 8'h01 : (in_data == 8'hFF) ? 8'hFE : in_data;
        t = "R6 data";
      end else if (mm == 2'b00) begin
        e = (hc % 2 == 1) ? 8'h10 : 8'h80;
        t = "R7 fill";
      end else begin
        e = 8'h00;
        t = mm[1] ? "R9 raw null" : "R8 sliced null";
      end
    end else if (hc >= ep && hc < ep + 4) begin
      idx = hc - ep;
      if (idx == 0) begin mf = field_in; mv = vblank_in; end
      e = (idx == 0) ? 8'hFF : (idx < 3) ? 8'h00 : st(mf, mv, 1'b1);
      t = mm[1] ? "R3 R5 R9 EAV" : "R2 R3 R5 EAV";
    end else begin
      e = tog ? 8'h10 : 8'h80;
      t = "R4 blank";
    end
    checks++;
    if (in_ready !== (hc >= sp + 4 && hc < ep)) begin
      errors++;
      $display("FAIL R6 in_ready: actual %0b expected %0b (pos %0d)", in_ready, (hc >= sp + 4 && hc < ep), hc);
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
    // advance the model as the design does at the coming edge
    if (hc >= ep && hc < ep + 4) tog = 1'b0;
    else if (!(hc >= sp && hc < ep)) tog = ~tog;
    if (hc == LINE_LEN - 1) begin
      hc = 0; line++;
      mm = fmt_sel; mrs = raw_start; mre = raw_stop;
    end else begin
      hc++;
    end
  endtask

  // monitor: compares each output byte against the scoreboard
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0 && !done) begin
      chk(out_byte, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    set_line(0,  2'b00, 8'd0, 8'd0,  0);
    set_line(1,  2'b00, 8'd0, 8'd0,  1);
    set_line(2,  2'b01, 8'd0, 8'd0,  1);
    set_line(3,  2'b10, 8'd3, 8'd12, 1);
    set_line(4,  2'b10, 8'd1, 8'd15, 0);
    set_line(5,  2'b10, 8'd0, 8'd2,  1);
    set_line(6,  2'b01, 8'd0, 8'd0,  0);
    set_line(7,  2'b00, 8'd0, 8'd0,  1);
    set_line(8,  2'b11, 8'd5, 8'd10, 1);
    set_line(9,  2'b00, 8'd0, 8'd0,  1);
    set_line(10, 2'b10, 8'd2, 8'd14, 1);
    set_line(11, 2'b01, 8'd0, 8'd0,  1);
    set_line(12, 2'b00, 8'd0, 8'd0,  0);
    set_line(13, 2'b00, 8'd0, 8'd0,  1);
    lfsr = 16'hACE1;
    rst_n = 1'b0; fmt_sel = 2'b10; raw_start = 8'd3; raw_stop = 8'd12;
    field_in = 1'b1; vblank_in = 1'b0; in_valid = 1'b1; in_data = 8'h55;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(out_byte, 8'h10, "R1 reset out_byte");
    chk({7'd0, in_ready}, 8'h00, "R1 reset in_ready");
    hc = 0; line = 0; mm = 2'b00; mrs = 8'd0; mre = 8'd0; mf = 1'b0; mv = 1'b1; tog = 1'b0;
    rst_n = 1'b1;
    for (int cyc = 0; cyc < NLINES * LINE_LEN; cyc++) begin
      drive_cycle();
      @(negedge clk);
    end
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule